// File: doc/BRIEF.md
# Receive Destination Address Filter

This block decides, for every incoming Ethernet frame, whether the receive path keeps it or drops it. A frame is presented as one strobe carrying its 48-bit destination address and its length. Two cycles later the block returns a single registered verdict: accept or reject. An accepted broadcast or multicast frame also carries a group flag.

The verdict follows a fixed priority:

1. The receive gate comes first. A link that is down, or a receiver that is suspended, refuses every frame.
2. The length check follows. A frame shorter than the configured minimum is dropped before any address is examined.
3. Promiscuous mode is next.
4. The broadcast rule is next.
5. The multicast rule is next. It uses a 64-bit hash table.
6. The last rule is an exact match against one individual address.

The multicast table is loaded through its own port. A load start gives the list size in bytes and clears the table. After that, each beat delivers one 48-bit address. The hash of that address sets one table bit. The number of beats that count is the byte size divided by six, capped at the table's entry limit.

The hash is a 6-bit field of a CRC-32 taken over the six address bytes. The CRC uses the reflected polynomial 0xEDB88320, an all-ones initial value and a final inversion. The octet at `[47:40]` is fed first, and each octet is fed least significant bit first. Bits 7:2 of the result select the table bit.

Top module: `rxaf_top`

## Requirements
- R1: For each cycle with `frm_valid` high, `dec_valid` is high exactly two clock cycles later for one cycle. While `dec_valid` is high exactly one of `dec_accept` and `dec_reject` is high. While it is low, `dec_accept`, `dec_reject` and `dec_group` are all low. After reset all four outputs are low.
- R2: The multicast hash index is bits 7:2 of a CRC-32 over the destination address, computed as follows:
  - reflected polynomial 0xEDB88320
  - initial value 0xFFFFFFFF
  - result inverted at the end
  - octets fed from `frm_dst[47:40]` down to `frm_dst[7:0]`
  - each octet fed bit 0 first

  The index selects one of 64 table bits.
- R3: The multicast table is loaded as follows:
  - Reset empties the table.
  - `tbl_load_start` clears the table and arms a count of `tbl_load_bytes / 6`, capped at 64.
  - Each `tbl_entry_valid` beat sets the bit for its address and uses up one count.
  - Beats that arrive once the count is used up, or in the same cycle as a load start, change nothing.
- R4: A frame whose strobe arrives while `link_up` is low or `rx_suspended` is high is rejected with `dec_group` low, whatever its address.
- R5: A frame with `frm_len` below max(`cfg_min_len`, 5) is rejected before any address rule applies, so promiscuous mode and broadcast cannot rescue it. A frame exactly at that limit passes the length check.
- R6: With `cfg_promisc` high, every frame that passes R4 and R5 is accepted with `dec_group` low.
- R7: A destination of all ones is broadcast. It is rejected when `cfg_bcast_block` is high. Otherwise it is accepted with `dec_group` high.
- R8: A destination that is not all ones and has `frm_dst[40]` set is multicast. It is rejected when `cfg_mcast_en` is low. Otherwise it is accepted, with `dec_group` high, exactly when its table bit is set.
- R9: Any other destination is accepted, with `dec_group` low, only when it equals `own_addr`. Otherwise it is rejected.
- R10: `dec_group` is never high without `dec_accept`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| link_up | input | 1 | Link status; low refuses frames |
| rx_suspended | input | 1 | Receiver suspended; high refuses frames |
| cfg_promisc | input | 1 | Accept every frame of adequate length |
| cfg_bcast_block | input | 1 | Reject broadcast frames |
| cfg_mcast_en | input | 1 | Allow multicast frames through the hash table |
| cfg_min_len | input | MINLEN_W (8) | Configured minimum frame length (floor of 5 applied) |
| own_addr | input | 48 | Individual address of this station |
| tbl_load_start | input | 1 | Clear the table and start a new list |
| tbl_load_bytes | input | CNT_W (16) | Size of the new list in bytes |
| tbl_entry_valid | input | 1 | One list address is present |
| tbl_entry_addr | input | 48 | List address to hash into the table |
| frm_valid | input | 1 | Frame destination strobe |
| frm_dst | input | 48 | Frame destination address, first octet in [47:40] |
| frm_len | input | LEN_W (12) | Frame length in bytes |
| dec_valid | output | 1 | Verdict present |
| dec_accept | output | 1 | Frame accepted |
| dec_reject | output | 1 | Frame rejected |
| dec_group | output | 1 | Accepted frame is broadcast or multicast |

## Verification
The bench builds the block with its default parameters: a 64-bit table, a 64-entry cap, a 16-bit byte count, 12-bit lengths and an 8-bit minimum-length field. With these values a list of 500 bytes asks for 83 entries. That is more than the cap allows, so the bench sends 70 beats and the beats past the 64th must be dropped. A minimum setting below 5 exposes the floor at lengths 4 and 5. A sweep of 64 multicast addresses against a one-entry table tests the hash bit selection, using the bench's own CRC formulation.

// File: rtl/rxaf_pkg.sv
package rxaf_pkg;

  localparam int unsigned ADDR_W = 48;
  localparam int unsigned OCTETS = ADDR_W / 8;
  localparam logic [31:0] CRC_POLY_REFL = 32'hEDB88320;

  // Reason the classifier chose, brought out for assertions.
  typedef enum logic [2:0] {
    VERD_GATED,
    VERD_SHORT,
    VERD_PROMISC,
    VERD_BCAST,
    VERD_MCAST,
    VERD_UNICAST
  } verdict_e;

  // CRC-32, reflected, init all ones, inverted result.
  // Octet [47:40] first, each octet bit 0 first.
  function automatic logic [31:0] crc32_addr(input logic [ADDR_W-1:0] addr);
    logic [31:0] c;
    logic [7:0]  oct;
    c = '1;
    for (int i = 0; i < int'(OCTETS); i++) begin
      oct = addr[ADDR_W-1-8*i -: 8];
      for (int j = 0; j < 8; j++) begin
        if (c[0] ^ oct[j]) c = (c >> 1) ^ CRC_POLY_REFL;
        else               c = c >> 1;
      end
    end
    return ~c;
  endfunction

endpackage

// File: rtl/rxaf_hash_unit.sv
module rxaf_hash_unit
  import rxaf_pkg::*;
#(
  parameter int unsigned HASH_W   = 6,
  parameter int unsigned HASH_LSB = 2
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [HASH_W-1:0] hash
);

  // Hash field sits at CRC bits [HASH_LSB +: HASH_W]   (R2)
  assign hash = HASH_W'(crc32_addr(addr) >> HASH_LSB);

endmodule

// File: rtl/rxaf_mcast_table.sv
module rxaf_mcast_table
  import rxaf_pkg::*;
#(
  parameter int unsigned TBL_BITS    = 64,
  parameter int unsigned MAX_ENTRIES = 64,
  parameter int unsigned CNT_W       = 16,
  parameter int unsigned HASH_W      = $clog2(TBL_BITS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_start,
  input  logic [CNT_W-1:0]  load_bytes,
  input  logic              entry_valid,
  input  logic [HASH_W-1:0] entry_hash,
  input  logic [HASH_W-1:0] look_hash,
  output logic              look_hit
);

  localparam int unsigned REM_W = $clog2(MAX_ENTRIES + 1);

  logic [TBL_BITS-1:0] tbl_q;
  logic [REM_W-1:0]    remaining_q;
  logic                entry_take;

  function automatic logic [REM_W-1:0] entries_of(input logic [CNT_W-1:0] nbytes);
    logic [CNT_W-1:0] q;
    q = nbytes / CNT_W'(OCTETS);
    if (q > CNT_W'(MAX_ENTRIES)) return REM_W'(MAX_ENTRIES);
    return REM_W'(q);
  endfunction

  // A start in the same cycle wins over an entry beat.
  assign entry_take = entry_valid && !load_start && (remaining_q != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          remaining_q <= '0;
    else if (load_start) remaining_q <= entries_of(load_bytes);
    else if (entry_take) remaining_q <= remaining_q - 1'b1;
  end

  for (genvar b = 0; b < TBL_BITS; b++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                         tbl_q[b] <= 1'b0;
      else if (load_start)                                tbl_q[b] <= 1'b0;
      else if (entry_take && entry_hash == HASH_W'(b))    tbl_q[b] <= 1'b1;
    end
  end

  assign look_hit = tbl_q[look_hash];

  AST_REMAIN_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    remaining_q <= REM_W'(MAX_ENTRIES)); // R3
  AST_LOAD_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    load_start |=> (tbl_q == '0)); // R3
  AST_SPENT_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (remaining_q == '0 && !load_start) |=> $stable(tbl_q)); // R3
  AST_ONE_BIT_PER_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
    !load_start |=> ($countones(tbl_q ^ $past(tbl_q)) <= 1)); // R3

endmodule

// File: rtl/rxaf_classifier.sv
module rxaf_classifier
  import rxaf_pkg::*;
#(
  parameter int unsigned LEN_W     = 12,
  parameter int unsigned MINLEN_W  = 8,
  parameter int unsigned HASH_W    = 6,
  parameter int unsigned MIN_FLOOR = 5
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                link_up,
  input  logic                rx_suspended,
  input  logic                cfg_promisc,
  input  logic                cfg_bcast_block,
  input  logic                cfg_mcast_en,
  input  logic [MINLEN_W-1:0] cfg_min_len,
  input  logic [ADDR_W-1:0]   own_addr,
  input  logic                frm_valid,
  input  logic [ADDR_W-1:0]   frm_dst,
  input  logic [LEN_W-1:0]    frm_len,
  input  logic [HASH_W-1:0]   frm_hash,
  output logic [HASH_W-1:0]   look_hash,
  input  logic                look_hit,
  output logic                dec_valid,
  output logic                dec_accept,
  output logic                dec_reject,
  output logic                dec_group
);

  localparam int unsigned GROUP_BIT = ADDR_W - 8;

  // Stage 1: sampled frame attributes
  logic              s1_valid, s1_gate, s1_short, s1_promisc;
  logic              s1_bcast, s1_group_addr, s1_own_hit;
  logic              s1_bc_block, s1_mc_en;
  logic [HASH_W-1:0] s1_hash;

  // Stage 2 combinational verdict
  verdict_e verdict;
  logic     verd_accept, verd_group;

  function automatic logic [LEN_W-1:0] eff_min(input logic [MINLEN_W-1:0] cfg);
    if (LEN_W'(cfg) < LEN_W'(MIN_FLOOR)) return LEN_W'(MIN_FLOOR);
    return LEN_W'(cfg);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_valid      <= 1'b0;
      s1_gate       <= 1'b0;
      s1_short      <= 1'b0;
      s1_promisc    <= 1'b0;
      s1_bcast      <= 1'b0;
      s1_group_addr <= 1'b0;
      s1_own_hit    <= 1'b0;
      s1_bc_block   <= 1'b0;
      s1_mc_en      <= 1'b0;
      s1_hash       <= '0;
    end else begin
      s1_valid      <= frm_valid;
      s1_gate       <= !link_up || rx_suspended;
      s1_short      <= frm_len < eff_min(cfg_min_len);
      s1_promisc    <= cfg_promisc;
      s1_bcast      <= &frm_dst;
      s1_group_addr <= frm_dst[GROUP_BIT];
      s1_own_hit    <= frm_dst == own_addr;
      s1_bc_block   <= cfg_bcast_block;
      s1_mc_en      <= cfg_mcast_en;
      s1_hash       <= frm_hash;
    end
  end

  assign look_hash = s1_hash;

  // Fixed priority: gate, length, promiscuous, broadcast, multicast, unicast
  always_comb begin
    verdict     = VERD_UNICAST;
    verd_accept = 1'b0;
    verd_group  = 1'b0;
    if (s1_gate) begin
      verdict = VERD_GATED;
    end else if (s1_short) begin
      verdict = VERD_SHORT;
    end else if (s1_promisc) begin
      verdict     = VERD_PROMISC;
      verd_accept = 1'b1;
    end else if (s1_bcast) begin
      verdict     = VERD_BCAST;
      verd_accept = !s1_bc_block;
      verd_group  = !s1_bc_block;
    end else if (s1_group_addr) begin
      verdict     = VERD_MCAST;
      verd_accept = s1_mc_en && look_hit;
      verd_group  = s1_mc_en && look_hit;
    end else begin
      verd_accept = s1_own_hit;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dec_valid  <= 1'b0;
      dec_accept <= 1'b0;
      dec_reject <= 1'b0;
      dec_group  <= 1'b0;
    end else begin
      dec_valid  <= s1_valid;
      dec_accept <= s1_valid && verd_accept;
      dec_reject <= s1_valid && !verd_accept;
      dec_group  <= s1_valid && verd_group;
    end
  end

  AST_FRAME_ADVANCES: assert property (@(posedge clk) disable iff (!rst_n)
    frm_valid |=> s1_valid); // R1
  AST_STAGE_ADVANCES: assert property (@(posedge clk) disable iff (!rst_n)
    s1_valid |=> dec_valid); // R1
  AST_ONE_VERDICT: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid |-> (dec_accept != dec_reject)); // R1
  AST_QUIET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !dec_valid |-> !(dec_accept || dec_reject || dec_group)); // R1
  AST_GATE_REJECTS: assert property (@(posedge clk) disable iff (!rst_n)
    (s1_valid && s1_gate) |=> (dec_reject && !dec_group)); // R4
  AST_SHORT_REJECTS: assert property (@(posedge clk) disable iff (!rst_n)
    (s1_valid && s1_short) |=> dec_reject); // R5
  AST_PROMISC_ACCEPTS: assert property (@(posedge clk) disable iff (!rst_n)
    (s1_valid && verdict == VERD_PROMISC) |=> (dec_accept && !dec_group)); // R6
  AST_BCAST_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (s1_valid && verdict == VERD_BCAST && s1_bc_block) |=> dec_reject); // R7
  AST_MCAST_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
    (s1_valid && verdict == VERD_MCAST && !s1_mc_en) |=> dec_reject); // R8
  AST_GROUP_NEEDS_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    dec_group |-> dec_accept); // R10

endmodule

// File: rtl/rxaf_top.sv
module rxaf_top
  import rxaf_pkg::*;
#(
  parameter int unsigned TBL_BITS    = 64,
  parameter int unsigned MAX_ENTRIES = 64,
  parameter int unsigned CNT_W       = 16,
  parameter int unsigned LEN_W       = 12,
  parameter int unsigned MINLEN_W    = 8,
  parameter int unsigned HASH_LSB    = 2,
  parameter int unsigned MIN_FLOOR   = 5
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                link_up,
  input  logic                rx_suspended,
  input  logic                cfg_promisc,
  input  logic                cfg_bcast_block,
  input  logic                cfg_mcast_en,
  input  logic [MINLEN_W-1:0] cfg_min_len,
  input  logic [47:0]         own_addr,
  input  logic                tbl_load_start,
  input  logic [CNT_W-1:0]    tbl_load_bytes,
  input  logic                tbl_entry_valid,
  input  logic [47:0]         tbl_entry_addr,
  input  logic                frm_valid,
  input  logic [47:0]         frm_dst,
  input  logic [LEN_W-1:0]    frm_len,
  output logic                dec_valid,
  output logic                dec_accept,
  output logic                dec_reject,
  output logic                dec_group
);

  localparam int unsigned HASH_W = $clog2(TBL_BITS);

  logic [HASH_W-1:0] entry_hash, frame_hash, look_hash;
  logic              look_hit;

  rxaf_hash_unit #(.HASH_W(HASH_W), .HASH_LSB(HASH_LSB)) u_hash_load (
    .addr (tbl_entry_addr),
    .hash (entry_hash)
  );

  rxaf_hash_unit #(.HASH_W(HASH_W), .HASH_LSB(HASH_LSB)) u_hash_frame (
    .addr (frm_dst),
    .hash (frame_hash)
  );

  rxaf_mcast_table #(
    .TBL_BITS(TBL_BITS), .MAX_ENTRIES(MAX_ENTRIES), .CNT_W(CNT_W), .HASH_W(HASH_W)
  ) u_table (
    .clk         (clk),
    .rst_n       (rst_n),
    .load_start  (tbl_load_start),
    .load_bytes  (tbl_load_bytes),
    .entry_valid (tbl_entry_valid),
    .entry_hash  (entry_hash),
    .look_hash   (look_hash),
    .look_hit    (look_hit)
  );

  rxaf_classifier #(
    .LEN_W(LEN_W), .MINLEN_W(MINLEN_W), .HASH_W(HASH_W), .MIN_FLOOR(MIN_FLOOR)
  ) u_class (
    .clk             (clk),
    .rst_n           (rst_n),
    .link_up         (link_up),
    .rx_suspended    (rx_suspended),
    .cfg_promisc     (cfg_promisc),
    .cfg_bcast_block (cfg_bcast_block),
    .cfg_mcast_en    (cfg_mcast_en),
    .cfg_min_len     (cfg_min_len),
    .own_addr        (own_addr),
    .frm_valid       (frm_valid),
    .frm_dst         (frm_dst),
    .frm_len         (frm_len),
    .frm_hash        (frame_hash),
    .look_hash       (look_hash),
    .look_hit        (look_hit),
    .dec_valid       (dec_valid),
    .dec_accept      (dec_accept),
    .dec_reject      (dec_reject),
    .dec_group       (dec_group)
  );

endmodule

// File: tb/rxaf_top_tb_top.sv
`timescale 1ns/1ps
module rxaf_top_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        link_up = 1'b1, rx_suspended = 1'b0;
  logic        cfg_promisc = 1'b0, cfg_bcast_block = 1'b0, cfg_mcast_en = 1'b0;
  logic [7:0]  cfg_min_len = 8'd0;
  logic [47:0] own_addr = 48'h02_11_22_33_44_55;
  logic        tbl_load_start = 1'b0;
  logic [15:0] tbl_load_bytes = '0;
  logic        tbl_entry_valid = 1'b0;
  logic [47:0] tbl_entry_addr = '0;
  logic        frm_valid = 1'b0;
  logic [47:0] frm_dst = '0;
  logic [11:0] frm_len = '0;
  logic        dec_valid, dec_accept, dec_reject, dec_group;

  always #4 clk = ~clk; // 125 MHz

  rxaf_top dut_i (
    .clk(clk), .rst_n(rst_n), .link_up(link_up), .rx_suspended(rx_suspended),
    .cfg_promisc(cfg_promisc), .cfg_bcast_block(cfg_bcast_block),
    .cfg_mcast_en(cfg_mcast_en), .cfg_min_len(cfg_min_len), .own_addr(own_addr),
    .tbl_load_start(tbl_load_start), .tbl_load_bytes(tbl_load_bytes),
    .tbl_entry_valid(tbl_entry_valid), .tbl_entry_addr(tbl_entry_addr),
    .frm_valid(frm_valid), .frm_dst(frm_dst), .frm_len(frm_len),
    .dec_valid(dec_valid), .dec_accept(dec_accept), .dec_reject(dec_reject),
    .dec_group(dec_group)
  );

  typedef struct {
    bit    acc;
    bit    grp;
    int    due;
    string req;
  } exp_t;

  exp_t  sb_q[$];
  int    checks = 0, errors = 0, cyc = 0;
  bit    done = 1'b0;
  bit    model_tbl [64];
  int    model_rem = 0;

  always @(posedge clk) cyc <= cyc + 1;

  // Bench CRC: mask form, octets pulled by shifting the address left.
  function automatic int model_hash(input logic [47:0] a);
    logic [31:0] r;
    logic [47:0] s;
    r = 32'hFFFF_FFFF;
    s = a;
    for (int k = 0; k < 6; k++) begin
      logic [7:0] o;
      o = s[47:40];
      s = s << 8;
      for (int t = 0; t < 8; t++)
        r = (r >> 1) ^ (32'hEDB8_8320 & {32{r[0] ^ o[t]}});
    end
    r = ~r;
    return int'(r[7:2]);
  endfunction

  task automatic check(input bit ok, input string req, input string what);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: %s", req, what);
    end
  endtask

  // Reference decision from the requirements
  task automatic model_decide(input logic [47:0] d, input int len,
                              output bit acc, output bit grp);
    int lim;
    lim = (int'(cfg_min_len) < 5) ? 5 : int'(cfg_min_len);
    acc = 0; grp = 0;
    if (!link_up || rx_suspended)       acc = 0;
    else if (len < lim)                 acc = 0;
    else if (cfg_promisc)               acc = 1;
    else if (d == 48'hFFFF_FFFF_FFFF) begin acc = !cfg_bcast_block; grp = acc; end
    else if (d[40])                 begin acc = cfg_mcast_en && model_tbl[model_hash(d)]; grp = acc; end
    else                                acc = (d == own_addr);
  endtask

  task automatic send(input logic [47:0] d, input int len, input string req);
    exp_t e;
    @(negedge clk);
    model_decide(d, len, e.acc, e.grp);
    e.due = cyc + 2;
    e.req = req;
    sb_q.push_back(e);
    frm_valid = 1'b1; frm_dst = d; frm_len = 12'(len);
    @(negedge clk);
    frm_valid = 1'b0;
  endtask

  task automatic load(input int nbytes, input int beats, input logic [47:0] base);
    @(negedge clk);
    tbl_load_start = 1'b1; tbl_load_bytes = 16'(nbytes);
    foreach (model_tbl[i]) model_tbl[i] = 0;
    model_rem = nbytes / 6;
    if (model_rem > 64) model_rem = 64;
    @(negedge clk);
    tbl_load_start = 1'b0;
    for (int b = 0; b < beats; b++) begin
      tbl_entry_valid = 1'b1;
      tbl_entry_addr  = base + 48'(b * 256);
      if (model_rem > 0) begin
        model_tbl[model_hash(tbl_entry_addr)] = 1;
        model_rem--;
      end
      @(negedge clk);
    end
    tbl_entry_valid = 1'b0;
    @(negedge clk);
  endtask

  // Monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n && dec_valid) begin
      if (sb_q.size() == 0) begin
        checks++; errors++;
        $display("FAIL R1: verdict with no frame outstanding (actual valid=1 expected valid=0)");
      end else begin
        exp_t e;
        e = sb_q.pop_front();
        checks++;
        if (dec_accept !== e.acc || dec_reject !== !e.acc || dec_group !== e.grp || cyc != e.due) begin
          errors++;
          $display("FAIL %s: actual acc=%0b rej=%0b grp=%0b cyc=%0d expected acc=%0b rej=%0b grp=%0b cyc=%0d",
                   e.req, dec_accept, dec_reject, dec_group, cyc, e.acc, !e.acc, e.grp, e.due);
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    foreach (model_tbl[i]) model_tbl[i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(dec_valid == 0 && dec_accept == 0 && dec_reject == 0 && dec_group == 0, "R1",
          $sformatf("reset outputs actual=%0b%0b%0b%0b expected=0000",
                    dec_valid, dec_accept, dec_reject, dec_group));
    // R3: table empty after reset
    cfg_mcast_en = 1'b1;
    send(48'h01_00_5E_00_00_01, 64, "R3_reset_empty");
    send(48'h01_00_5E_12_34_56, 64, "R3_reset_empty");
    cfg_mcast_en = 1'b0;

    // R9 individual address
    send(own_addr, 64, "R9_match");
    send(48'h02_11_22_33_44_56, 64, "R9_mismatch");
    // R1 back-to-back frames
    send(own_addr, 64, "R1_b2b");
    send(48'h00_00_00_00_00_00, 64, "R1_b2b");

    // R7 broadcast
    send(48'hFFFF_FFFF_FFFF, 64, "R7_accept");
    cfg_bcast_block = 1'b1;
    send(48'hFFFF_FFFF_FFFF, 64, "R7_blocked");
    cfg_bcast_block = 1'b0;

    // R8 multicast via table; extra beat beyond count ignored (R3)
    load(18, 4, 48'h01_00_5E_00_10_01);
    cfg_mcast_en = 1'b1;
    for (int b = 0; b < 4; b++) send(48'h01_00_5E_00_10_01 + 48'(b * 256), 64, "R8_table");
    send(48'h01_00_5E_55_00_07, 64, "R8_table_miss");
    cfg_mcast_en = 1'b0;
    send(48'h01_00_5E_00_10_01, 64, "R8_disabled");
    cfg_mcast_en = 1'b1;

    // R3 reload clears previous list
    load(6, 1, 48'h01_00_5E_77_00_01);
    for (int b = 0; b < 3; b++) send(48'h01_00_5E_00_10_01 + 48'(b * 256), 64, "R3_reload");
    send(48'h01_00_5E_77_00_01, 64, "R3_reload");

    // R2 hash selection sweep against one entry
    for (int k = 0; k < 64; k++) send(48'h01_00_5E_00_01_00 + 48'(k * 3), 64, "R2_hash");

    // R3 cap at 64 entries
    load(500, 70, 48'h01_00_5E_7F_00_33);
    for (int b = 0; b < 70; b++) send(48'h01_00_5E_7F_00_33 + 48'(b * 256), 64, "R3_cap");
    for (int k = 0; k < 16; k++) send(48'h03_AA_00_00_00_00 + 48'(k * 97), 64, "R3_cap_probe");

    // R6 promiscuous
    cfg_promisc = 1'b1;
    send(48'h02_99_99_99_99_99, 64, "R6_unicast");
    send(48'h01_00_5E_7E_7E_7E, 64, "R6_mcast");
    send(48'hFFFF_FFFF_FFFF, 64, "R6_bcast");

    // R5 length floor and configured minimum
    cfg_min_len = 8'd0;
    send(48'h02_99_99_99_99_99, 4, "R5_floor_short");
    send(48'h02_99_99_99_99_99, 5, "R5_floor_edge");
    cfg_promisc = 1'b0;
    cfg_min_len = 8'd64;
    send(48'hFFFF_FFFF_FFFF, 63, "R5_min_short");
    send(48'hFFFF_FFFF_FFFF, 64, "R5_min_edge");
    send(own_addr, 10, "R5_min_short");

    // R4 receive gate
    link_up = 1'b0;
    send(own_addr, 64, "R4_link_down");
    send(48'hFFFF_FFFF_FFFF, 64, "R4_link_down");
    link_up = 1'b1;
    rx_suspended = 1'b1;
    cfg_promisc = 1'b1;
    send(own_addr, 64, "R4_suspended");
    rx_suspended = 1'b0;
    send(own_addr, 64, "R4_resumed");
    cfg_promisc = 1'b0;

    repeat (6) @(negedge clk);
    check(sb_q.size() == 0, "R1",
          $sformatf("outstanding verdicts actual=%0d expected=0", sb_q.size()));
    check(dec_valid == 0, "R1",
          $sformatf("idle valid actual=%0b expected=0", dec_valid));
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule